// File: doc/BRIEF.md
# Indexed VGA Register Port with Locked Auxiliary DAC Register

This block is the byte-wide register front end of a VGA-style display controller. A host reaches it through a plain memory-mapped port: a small byte address, separate write and read strobes, write data in and read data out. Behind the port sit three indexed register banks: the sequencer, the CRT controller and the graphics controller. Each bank appears as an index byte and a data byte at two fixed offsets. A data access reaches the bank register selected by the low bits of that bank's current index. The full contents of every bank are driven out for the rest of the controller to use.

The port also holds a pixel mask register and an auxiliary DAC control register that has no address of its own. To reach it, the host reads the pixel mask offset four times in a row. The next write to the pixel mask offset then lands in the auxiliary register, and the pixel mask keeps its value. Any write to the pixel mask offset, and any access to another offset, restarts the count. Read data is combinational: `rd_data` shows, in the same cycle, the value stored at `addr`. Writes and counter updates take effect at the rising clock edge.

Top module: `vga_regport`

## Requirements
- R1: After reset, every bank register, every bank index, the pixel mask, the auxiliary DAC register and the unlock count are zero.
- R2: The sequencer index is at offset 0x04 and its data is at offset 0x05. A data write stores into the register selected by bits [4:0] of the index, and a data read returns that register. Bank register n appears on bits [8n+7:8n] of `seq_regs`.
- R3: The CRT controller index is at offset 0x14 and its data is at offset 0x15. It selects registers and lays them out on `crt_regs` in the same way as R2.
- R4: The graphics controller index is at offset 0x0E and its data is at offset 0x0F. It selects registers and lays them out on `gfx_regs` in the same way as R2.
- R5: Reading an index offset returns all 8 bits last written to it, including bits 7:5, which take no part in selection.
- R6: Offset 0x06 reads and writes the pixel mask. A read there returns the pixel mask value whatever the unlock count is.
- R7: After four back-to-back reads of offset 0x06, the next write to 0x06 stores into the auxiliary DAC register and leaves the pixel mask unchanged.
- R8: After that redirected write the count is zero, so a following write to 0x06 reaches the pixel mask again.
- R9: A write to 0x06 made after fewer than four reads stores into the pixel mask, leaves the auxiliary register unchanged, and clears the count.
- R10: A read or write of any offset other than 0x06 clears the unlock count.
- R11: Reads of 0x06 beyond the fourth keep the port unlocked, so the next write to 0x06 still goes to the auxiliary register.
- R12: Reads of an unmapped offset return 0xFF. Writes to an unmapped offset change no register. Such an access clears the count (R10).
- R13: When `wr_en` and `rd_en` are high together, the access is handled as a write only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 5 | Byte offset within the register window |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pixel_mask | output | 8 | Current pixel mask |
| hidden_dac | output | 8 | Current auxiliary DAC control value |
| seq_regs | output | 256 | Sequencer bank, register n at [8n+7:8n] |
| crt_regs | output | 256 | CRT controller bank, same layout |
| gfx_regs | output | 256 | Graphics controller bank, same layout |

## Verification
The auxiliary register is the hardest state to reach from the ports. It needs an unbroken run of at least four pixel-mask reads followed by a pixel-mask write, and uniform random traffic almost never produces that run. The stimulus therefore mixes directed sequences with random ones: exactly three reads then a write, four reads then a write, six reads then a write, and a run broken by an access elsewhere. The random phase also injects runs of pixel-mask reads with random lengths from two to six, and each run ends in either a write or a stray access. This way both the locked path and the unlocked path of the write are hit many times under random data.

// File: rtl/vga_regport_pkg.sv
package vga_regport_pkg;

    localparam int DATA_W       = 8;
    localparam int BANK_REGS    = 32;
    localparam int UNLOCK_READS = 4;

    localparam int OFF_SEQ_IDX  = 'h04;
    localparam int OFF_SEQ_DAT  = 'h05;
    localparam int OFF_PIX_MASK = 'h06;
    localparam int OFF_GFX_IDX  = 'h0E;
    localparam int OFF_GFX_DAT  = 'h0F;
    localparam int OFF_CRT_IDX  = 'h14;
    localparam int OFF_CRT_DAT  = 'h15;

    localparam logic [DATA_W-1:0] UNMAPPED_READ = '1;

    typedef enum logic [1:0] {
        BANK_SEQ = 2'd0,
        BANK_CRT = 2'd1,
        BANK_GFX = 2'd2
    } bank_sel_e;

endpackage

// File: rtl/vga_index_bank.sv
module vga_index_bank #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         idx_we,
    input  logic                         dat_we,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            idx_val,
    output logic [DATA_W-1:0]            dat_val,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

    localparam int SEL_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic [DATA_W-1:0]                 idx;
        logic [NUM_REGS-1:0][DATA_W-1:0]   regs;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [SEL_W-1:0] sel;

    assign sel = st_q.idx[SEL_W-1:0];

    always_comb begin
        st_d = st_q;
        if (idx_we) begin
            st_d.idx = wdata;
        end
        if (dat_we) begin
            st_d.regs[sel] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_val   = st_q.idx;
    assign dat_val   = st_q.regs[sel];
    assign regs_flat = st_q.regs;

    // R2: bank contents move only on a data write
    a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_we |=> $stable(st_q.regs));

    // R2: a data write lands in the register chosen by the index held at the write
    a_r2_data_lands: assert property (@(posedge clk) disable iff (!rst_n)
        dat_we |=> st_q.regs[$past(sel)] == $past(wdata));

    // R5: the index keeps all eight written bits
    a_r5_index_full: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> idx_val == $past(wdata));

endmodule

// File: rtl/vga_hidden_unlock.sv
module vga_hidden_unlock #(
    parameter int DATA_W       = 8,
    parameter int UNLOCK_READS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_rd,
    input  logic              mask_wr,
    input  logic              other_acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pixel_mask,
    output logic [DATA_W-1:0] hidden_dac
);

    localparam int CNT_W = $clog2(UNLOCK_READS + 1);
    localparam logic [CNT_W-1:0] CNT_OPEN = CNT_W'(UNLOCK_READS);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] hidden;
    } unlock_state_t;

    unlock_state_t st_d, st_q;
    logic unlocked;

    assign unlocked = (st_q.cnt == CNT_OPEN);

    always_comb begin
        st_d = st_q;
        if (mask_wr) begin
            if (unlocked) begin
                st_d.hidden = wdata;
            end else begin
                st_d.mask = wdata;
            end
            st_d.cnt = '0;
        end else if (mask_rd) begin
            if (!unlocked) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (other_acc) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pixel_mask = st_q.mask;
    assign hidden_dac = st_q.hidden;

    // R11: the count never passes the unlocked value
    a_r11_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_OPEN);

    // R10: an access elsewhere restarts the sequence
    a_r10_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
        other_acc |=> st_q.cnt == '0);

    // R8: every pixel-mask write leaves the count at zero
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> st_q.cnt == '0);

    // R7: an unlocked write reaches the auxiliary register only
    a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && unlocked) |=> (hidden_dac == $past(wdata)) && $stable(pixel_mask));

    // R9: a locked write reaches the pixel mask only
    a_r9_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !unlocked) |=> (pixel_mask == $past(wdata)) && $stable(hidden_dac));

endmodule

// File: rtl/vga_regport.sv
module vga_regport
    import vga_regport_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [DATA_W-1:0]           rd_data,
    output logic [DATA_W-1:0]           pixel_mask,
    output logic [DATA_W-1:0]           hidden_dac,
    output logic [BANK_REGS*DATA_W-1:0] seq_regs,
    output logic [BANK_REGS*DATA_W-1:0] crt_regs,
    output logic [BANK_REGS*DATA_W-1:0] gfx_regs
);

    localparam int NUM_BANKS = 3;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t IDX_OFF [NUM_BANKS] = '{addr_t'(OFF_SEQ_IDX), addr_t'(OFF_CRT_IDX), addr_t'(OFF_GFX_IDX)};
    localparam addr_t DAT_OFF [NUM_BANKS] = '{addr_t'(OFF_SEQ_DAT), addr_t'(OFF_CRT_DAT), addr_t'(OFF_GFX_DAT)};

    logic do_wr, do_rd, any_acc, hit_mask;
    logic [NUM_BANKS-1:0]            hit_idx, hit_dat;
    logic [DATA_W-1:0]               idx_val [NUM_BANKS];
    logic [DATA_W-1:0]               dat_val [NUM_BANKS];
    logic [BANK_REGS*DATA_W-1:0]     flat    [NUM_BANKS];

    assign do_wr    = wr_en;
    assign do_rd    = rd_en && !wr_en;
    assign any_acc  = wr_en || rd_en;
    assign hit_mask = (addr == addr_t'(OFF_PIX_MASK));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit_idx[b] = (addr == IDX_OFF[b]);
        assign hit_dat[b] = (addr == DAT_OFF[b]);

        vga_index_bank #(
            .DATA_W   (DATA_W),
            .NUM_REGS (BANK_REGS)
        ) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .idx_we    (do_wr && hit_idx[b]),
            .dat_we    (do_wr && hit_dat[b]),
            .wdata     (wr_data),
            .idx_val   (idx_val[b]),
            .dat_val   (dat_val[b]),
            .regs_flat (flat[b])
        );
    end

    vga_hidden_unlock #(
        .DATA_W       (DATA_W),
        .UNLOCK_READS (UNLOCK_READS)
    ) unlock_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_rd    (do_rd && hit_mask),
        .mask_wr    (do_wr && hit_mask),
        .other_acc  (any_acc && !hit_mask),
        .wdata      (wr_data),
        .pixel_mask (pixel_mask),
        .hidden_dac (hidden_dac)
    );

    assign seq_regs = flat[BANK_SEQ];
    assign crt_regs = flat[BANK_CRT];
    assign gfx_regs = flat[BANK_GFX];

    always_comb begin
        rd_data = UNMAPPED_READ;
        if (hit_mask) begin
            rd_data = pixel_mask;
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_idx[b]) rd_data = idx_val[b];
            if (hit_dat[b]) rd_data = dat_val[b];
        end
    end

    // R12: an unmapped offset reads as all ones
    a_r12_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_mask && hit_idx == '0 && hit_dat == '0) |-> rd_data == UNMAPPED_READ);

    // R12: an unmapped write leaves every bank and both single registers unchanged
    a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_mask && hit_idx == '0 && hit_dat == '0)
        |=> $stable(seq_regs) && $stable(crt_regs) && $stable(gfx_regs)
            && $stable(pixel_mask) && $stable(hidden_dac));

    // R6: a pixel-mask read returns the pixel mask
    a_r6_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_mask) |-> rd_data == pixel_mask);

endmodule

// File: tb/vga_regport_tb_top.sv
module vga_regport_tb_top;

    localparam int AW = 5;
    localparam int NR = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data, pixel_mask, hidden_dac;
    logic [NR*8-1:0] seq_regs, crt_regs, gfx_regs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_seq [NR];
    logic [7:0] m_crt [NR];
    logic [7:0] m_gfx [NR];
    logic [7:0] m_si, m_ci, m_gi, m_mask, m_hid;
    int         m_cnt;

    always #4 clk = ~clk;

    vga_regport #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .pixel_mask(pixel_mask),
        .hidden_dac(hidden_dac), .seq_regs(seq_regs), .crt_regs(crt_regs),
        .gfx_regs(gfx_regs)
    );

    function automatic logic [7:0] model_rd(input logic [4:0] a);
        case (a)
            5'h04: return m_si;
            5'h05: return m_seq[m_si[4:0]];
            5'h06: return m_mask;
            5'h0E: return m_gi;
            5'h0F: return m_gfx[m_gi[4:0]];
            5'h14: return m_ci;
            5'h15: return m_crt[m_ci[4:0]];
            default: return 8'hFF;
        endcase
    endfunction

    function automatic string rd_tag(input logic [4:0] a);
        case (a)
            5'h04, 5'h14, 5'h0E: return "R5";
            5'h05: return "R2";
            5'h15: return "R3";
            5'h0F: return "R4";
            5'h06: return "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic model_step(input bit w, input bit r, input logic [4:0] a, input logic [7:0] d);
        if (w) begin
            case (a)
                5'h04: m_si = d;
                5'h05: m_seq[m_si[4:0]] = d;
                5'h0E: m_gi = d;
                5'h0F: m_gfx[m_gi[4:0]] = d;
                5'h14: m_ci = d;
                5'h15: m_crt[m_ci[4:0]] = d;
                5'h06: begin
                    if (m_cnt == 4) m_hid = d;
                    else m_mask = d;
                end
                default: ;
            endcase
            m_cnt = 0;
        end else if (r) begin
            if (a == 5'h06) m_cnt = (m_cnt < 4) ? m_cnt + 1 : 4;
            else m_cnt = 0;
        end
    endtask

    function automatic logic [NR*8-1:0] pack_bank(input int which);
        logic [NR*8-1:0] v;
        for (int i = 0; i < NR; i++) begin
            case (which)
                0: v[i*8 +: 8] = m_seq[i];
                1: v[i*8 +: 8] = m_crt[i];
                default: v[i*8 +: 8] = m_gfx[i];
            endcase
        end
        return v;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        checks++;
        if (pixel_mask !== m_mask || hidden_dac !== m_hid ||
            seq_regs !== pack_bank(0) || crt_regs !== pack_bank(1) || gfx_regs !== pack_bank(2)) begin
            errors++;
            $display("FAIL %s: actual mask %02h aux %02h expected mask %02h aux %02h (banks %0d%0d%0d)",
                     tag, pixel_mask, hidden_dac, m_mask, m_hid,
                     seq_regs === pack_bank(0), crt_regs === pack_bank(1), gfx_regs === pack_bank(2));
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic op(input bit w, input bit r, input logic [4:0] a, input logic [7:0] d, input string tag);
        addr = a; wr_en = w; rd_en = r; wr_data = d;
        #2;
        if (r && !w) check8(rd_tag(a), rd_data, model_rd(a));
        @(posedge clk);
        model_step(w, r, a, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_outputs(tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
        op(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        op(1'b0, 1'b1, a, 8'h00, tag);
    endtask

    function automatic logic [4:0] pick_addr();
        int k = $urandom_range(0, 9);
        case (k)
            0: return 5'h04; 1: return 5'h05; 2: return 5'h06;
            3: return 5'h0E; 4: return 5'h0F; 5: return 5'h14;
            6: return 5'h15; 7: return 5'h06;
            default: return 5'($urandom_range(0, 31));
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5813));
        for (int i = 0; i < NR; i++) begin
            m_seq[i] = '0; m_crt[i] = '0; m_gfx[i] = '0;
        end
        m_si = '0; m_ci = '0; m_gi = '0; m_mask = '0; m_hid = '0; m_cnt = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check_outputs("R1");
        rd(5'h05, "R1"); rd(5'h15, "R1"); rd(5'h0F, "R1"); rd(5'h14, "R1");

        // R2 R3 R4 R5: index selection uses bits 4:0, full index reads back
        wr(5'h04, 8'hE5, "R5"); wr(5'h05, 8'h5A, "R2"); rd(5'h04, "R5"); rd(5'h05, "R2");
        check8("R2", seq_regs[5*8 +: 8], 8'h5A);
        wr(5'h14, 8'h3F, "R3"); wr(5'h15, 8'hC3, "R3"); rd(5'h15, "R3");
        check8("R3", crt_regs[31*8 +: 8], 8'hC3);
        wr(5'h0E, 8'h40, "R4"); wr(5'h0F, 8'h77, "R4"); rd(5'h0F, "R4");
        check8("R4", gfx_regs[0 +: 8], 8'h77);

        // R6 R9: three reads then a write reaches the pixel mask
        wr(5'h06, 8'h11, "R6");
        for (int i = 0; i < 3; i++) rd(5'h06, "R6");
        wr(5'h06, 8'h22, "R9");
        check8("R9", hidden_dac, 8'h00);

        // R7 R8: four reads then the write is redirected, then the mask again
        for (int i = 0; i < 4; i++) rd(5'h06, "R7");
        wr(5'h06, 8'hA5, "R7");
        check8("R7", hidden_dac, 8'hA5);
        check8("R7", pixel_mask, 8'h22);
        wr(5'h06, 8'h3C, "R8");
        check8("R8", pixel_mask, 8'h3C);

        // R10: an access elsewhere breaks the run
        rd(5'h06, "R10"); rd(5'h06, "R10"); rd(5'h05, "R10"); rd(5'h06, "R10"); rd(5'h06, "R10");
        wr(5'h06, 8'h66, "R10");
        check8("R10", pixel_mask, 8'h66);

        // R11: six reads still unlocked
        for (int i = 0; i < 6; i++) rd(5'h06, "R11");
        wr(5'h06, 8'h9B, "R11");
        check8("R11", hidden_dac, 8'h9B);

        // R12: unmapped offsets
        rd(5'h00, "R12"); rd(5'h1F, "R12"); rd(5'h07, "R12");
        wr(5'h07, 8'hFF, "R12"); wr(5'h16, 8'h12, "R12");
        for (int i = 0; i < 4; i++) rd(5'h06, "R12");
        rd(5'h10, "R12");
        wr(5'h06, 8'h44, "R12");
        check8("R12", pixel_mask, 8'h44);

        // R13: both strobes high act as a write
        for (int i = 0; i < 4; i++) rd(5'h06, "R13");
        op(1'b1, 1'b1, 5'h06, 8'h5D, "R13");
        check8("R13", hidden_dac, 8'h5D);
        op(1'b1, 1'b1, 5'h04, 8'h08, "R13");
        rd(5'h04, "R13");

        // random phase with injected pixel-mask read runs
        for (int n = 0; n < 1500; n++) begin
            if ($urandom_range(0, 7) == 0) begin
                int len = $urandom_range(2, 6);
                for (int j = 0; j < len; j++) rd(5'h06, "R7");
                if ($urandom_range(0, 3) == 0) rd(pick_addr(), "R10");
                wr(5'h06, 8'($urandom()), "R7");
            end else begin
                bit w = $urandom_range(0, 1) == 1;
                op(w, !w || ($urandom_range(0, 15) == 0), pick_addr(), 8'($urandom()), "R2");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule